// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple byte-wide register bus. One down counter serves two consecutive stages: it first runs out a stage-one preload and then a stage-two preload. When stage two runs out, the block raises a timeout status flag and toggles a timeout pin. If enabled, it also emits a fixed-length reset request tagged as warm or cold. Software keeps the system alive by reloading the counter before stage two expires.

The preload registers and the reload/clear byte are protected. Each write to them must be preceded by a two-byte key written to the key offset. The enable lives next to a sticky lock bit. Once the lock is set, the watchdog cannot be switched off until the next hardware reset.

The register bus has no handshake and no back-pressure. A write strobe is taken in the cycle it is high. A read strobe latches the addressed byte onto the read data port, where it stays until the next read.

Top module: `wdog_twostage`

## Requirements
- R1: The stage-one preload occupies byte offsets 0x00-0x03 and the stage-two preload occupies 0x04-0x07, least significant byte first. Only bits [PRE_W-1:0] are stored; other bits read back as 0. With PRE_W=20, writing 0xFF to byte 2 reads back 0x0F, and byte 3 always reads 0.
- R2: A write to a preload byte or to the reload/clear byte at 0x0D takes effect only if the last two writes to 0x0C were 0x80 and then 0x86. Without this key, the write leaves all state unchanged.
- R3: The key is spent by the next protected write, whether or not that write changes anything. Any byte other than 0x80 or 0x86 written to 0x0C cancels a partial key.
- R4: A stage loads the counter with its preload in bits [CNT_W-1:LOW_W] and zeros below. The stage ends on the first counter tick that finds the whole counter at zero. A stage therefore lasts P*2^LOW_W+1 ticks, and stage two follows stage one directly.
- R5: Control bit 2 (at 0x10) set makes the counter tick once every 2^PRESC_W clocks, with the first tick 2^PRESC_W clocks after enable or reload. When the bit is clear, the counter ticks every clock.
- R6: When stage two expires, the timeout flag (readable as bit 1 of 0x0D) is set. A keyed write of bit 1 to 0x0D clears it; an unkeyed write does not.
- R7: When stage two expires and control bit 4 is 1, rst_req goes high for RST_LEN clocks, starting in the same cycle as the flag. When control bit 4 is 0, rst_req stays low.
- R8: rst_warm carries control bit 3 as sampled at the start of each reset request (1 = warm, 0 = cold).
- R9: tout_pin toggles on each stage-two expiry unless control bit 5 is 1.
- R10: In the lock/enable register at 0x18, bit 0 is the lock and bit 1 is the enable. The lock cannot be cleared except by hardware reset. While the lock is set, a write that clears the enable has no effect.
- R11: The counter moves only while enabled. While disabled, it holds the stage-one load. A keyed write of bit 0 to 0x0D restarts stage one. Offsets 0x14-0x17 read back the top 32 counter bits, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Byte latched by the last read |
| rst_req | output | 1 | Reset request pulse |
| rst_warm | output | 1 | Reset type, 1 = warm |
| tout_flag | output | 1 | Timeout status |
| tout_pin | output | 1 | Toggles on each timeout |

## Verification
The expiry timing is driven with several preload pairs: a zero first preload (instantaneous stage one), a non-zero first preload, and both preloads large. Comparing the measured expiry cycle across these pairs separates a wrong stage-one length from a wrong stage-two length. Running the same pair with the prescaler on confirms that the tick rate scales the whole period. For the key, the bench writes preloads with no key, with a broken key, and with a second write after one key; these cases separate a missing key check from a key that is never spent. Keep-alive reloads, disabling with and without the lock, and cold versus warm reset with the pin toggle masked cover the remaining control bits.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFS_PRE1 = 8'h00;
  localparam logic [7:0] OFS_PRE2 = 8'h04;
  localparam logic [7:0] OFS_KEY  = 8'h0C;
  localparam logic [7:0] OFS_KICK = 8'h0D;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_CNT  = 8'h14;
  localparam logic [7:0] OFS_LOCK = 8'h18;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  localparam int CTL_PRESC = 2;
  localparam int CTL_WARM  = 3;
  localparam int CTL_RSTEN = 4;
  localparam int CTL_NOTOG = 5;
  localparam logic [7:0] CTL_MASK = 8'h3C;

  localparam int KICK_RELOAD = 0;
  localparam int KICK_CLEAR  = 1;

  localparam int LK_LOCK = 0;
  localparam int LK_EN   = 1;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic {ST_ONE, ST_TWO} stage_e;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       prot_wr,
  output logic       grant,
  output logic       is_open
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr) begin
      case (st_q)
        UL_HALF: begin
          if (key_byte == KEY_SECOND)     st_d = UL_OPEN;
          else if (key_byte == KEY_FIRST) st_d = UL_HALF;
          else                            st_d = UL_IDLE;
        end
        default: begin
          if (key_byte == KEY_FIRST) st_d = UL_HALF;
          else                       st_d = UL_IDLE;
        end
      endcase
    end else if (prot_wr) begin
      st_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign is_open = (st_q == UL_OPEN);
  assign grant   = prot_wr & is_open;
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int PRESC_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  input  logic restart,
  output logic tick
);
  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (!run || restart) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  assign tick = slow ? (div_q == {PRESC_W{1'b1}}) : 1'b1;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int PRE_W = 20,
  parameter int LOW_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             reload,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic [31:0]      cnt_view,
  output logic             expire
);
  localparam int CNT_W = PRE_W + LOW_W;

  logic [CNT_W-1:0] cnt_q;
  stage_e           stg_q;
  logic             at_zero;
  logic             step;

  assign at_zero = (cnt_q == '0);
  assign step    = run & tick & ~reload;
  assign expire  = step & at_zero & (stg_q == ST_TWO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stg_q <= ST_ONE;
    end else if (!run || reload) begin
      stg_q <= ST_ONE;
      cnt_q <= {pre1, {LOW_W{1'b0}}};
    end else if (step) begin
      if (at_zero) begin
        if (stg_q == ST_ONE) begin
          stg_q <= ST_TWO;
          cnt_q <= {pre2, {LOW_W{1'b0}}};
        end else begin
          stg_q <= ST_ONE;
          cnt_q <= {pre1, {LOW_W{1'b0}}};
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  generate
    if (CNT_W > 32) begin : g_view_top
      assign cnt_view = cnt_q[CNT_W-1 -: 32];
    end else begin : g_view_ext
      assign cnt_view = 32'(cnt_q);
    end
  endgenerate
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic warm_in,
  output logic req,
  output logic warm
);
  localparam int LEN_W = $clog2(RST_LEN + 1);

  logic [LEN_W-1:0] rem_q;
  logic             warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      warm_q <= 1'b0;
    end else if (fire) begin
      rem_q  <= LEN_W'(RST_LEN);
      warm_q <= warm_in;
    end else if (rem_q != '0) begin
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign req  = (rem_q != '0);
  assign warm = warm_q;
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int PRE_W   = 20,
  parameter int LOW_W   = 15,
  parameter int PRESC_W = 10,
  parameter int RST_LEN = 16,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              rst_req,
  output logic              rst_warm,
  output logic              tout_flag,
  output logic              tout_pin
);
  localparam logic [31:0] PRE_MASK = (PRE_W >= 32) ? 32'hFFFF_FFFF
                                                   : ((32'd1 << PRE_W) - 32'd1);

  logic [7:0]  a8;
  logic [4:0]  boff;
  logic        is_pre1, is_pre2, is_kick, is_cnt;
  logic        key_wr, prot_wr, grant, ul_open;
  logic [31:0] pre1_q, pre2_q;
  logic [7:0]  ctrl_q;
  logic        lock_q, en_q;
  logic        kick_reload, kick_clear;
  logic        tick, expire, fire;
  logic [31:0] cnt_view;
  logic        tflag_q, tpin_q;
  logic [7:0]  rd_mux, rdata_q;

  assign a8      = 8'(bus_addr);
  assign boff    = {bus_addr[1:0], 3'b000};
  assign is_pre1 = (a8[7:2] == OFS_PRE1[7:2]);
  assign is_pre2 = (a8[7:2] == OFS_PRE2[7:2]);
  assign is_cnt  = (a8[7:2] == OFS_CNT[7:2]);
  assign is_kick = (a8 == OFS_KICK);
  assign key_wr  = bus_wr & (a8 == OFS_KEY);
  assign prot_wr = bus_wr & (is_pre1 | is_pre2 | is_kick);

  wdog_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (bus_wdata),
    .prot_wr  (prot_wr),
    .grant    (grant),
    .is_open  (ul_open)
  );

  assign kick_reload = grant & is_kick & bus_wdata[KICK_RELOAD];
  assign kick_clear  = grant & is_kick & bus_wdata[KICK_CLEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q <= '0;
      pre2_q <= '0;
    end else if (grant) begin
      if (is_pre1) pre1_q[boff +: 8] <= bus_wdata & PRE_MASK[boff +: 8];
      if (is_pre2) pre2_q[boff +: 8] <= bus_wdata & PRE_MASK[boff +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (bus_wr) begin
      if (a8 == OFS_CTRL) ctrl_q <= bus_wdata & CTL_MASK;
      if (a8 == OFS_LOCK) begin
        lock_q <= lock_q | bus_wdata[LK_LOCK];
        en_q   <= bus_wdata[LK_EN] | (lock_q & en_q);
      end
    end
  end

  wdog_tick #(.PRESC_W(PRESC_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .slow    (ctrl_q[CTL_PRESC]),
    .restart (kick_reload),
    .tick    (tick)
  );

  wdog_core #(.PRE_W(PRE_W), .LOW_W(LOW_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_q),
    .tick     (tick),
    .reload   (kick_reload),
    .pre1     (pre1_q[PRE_W-1:0]),
    .pre2     (pre2_q[PRE_W-1:0]),
    .cnt_view (cnt_view),
    .expire   (expire)
  );

  assign fire = expire & ctrl_q[CTL_RSTEN];

  wdog_stretch #(.RST_LEN(RST_LEN)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .warm_in (ctrl_q[CTL_WARM]),
    .req     (rst_req),
    .warm    (rst_warm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tflag_q <= 1'b0;
      tpin_q  <= 1'b0;
    end else begin
      if (expire)          tflag_q <= 1'b1;
      else if (kick_clear) tflag_q <= 1'b0;
      if (expire && !ctrl_q[CTL_NOTOG]) tpin_q <= ~tpin_q;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (is_pre1)              rd_mux = pre1_q[boff +: 8];
    else if (is_pre2)         rd_mux = pre2_q[boff +: 8];
    else if (is_cnt)          rd_mux = cnt_view[boff +: 8];
    else if (is_kick)         rd_mux = {6'b0, tflag_q, 1'b0};
    else if (a8 == OFS_CTRL)  rd_mux = ctrl_q;
    else if (a8 == OFS_LOCK)  rd_mux = {6'b0, en_q, lock_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign tout_flag = tflag_q;
  assign tout_pin  = tpin_q;
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int RST_LEN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_req,
  input logic        rst_warm,
  input logic        tout_flag,
  input logic        expire,
  input logic        fire,
  input logic        lock_q,
  input logic        en_q,
  input logic        ul_open,
  input logic [31:0] pre1_q,
  input logic [31:0] pre2_q
);
  localparam int HL_W = $clog2(RST_LEN + 2);
  logic [HL_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (rst_req) hi_len <= (hi_len == HL_W'(RST_LEN)) ? hi_len : hi_len + 1'b1;
    else              hi_len <= '0;
  end

  assert_pre1_keyed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pre1_q) |-> $past(ul_open));
  assert_pre2_keyed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pre2_q) |-> $past(ul_open));
  assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_flag) |-> $past(expire));
  assert_req_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(fire));
  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (hi_len >= HL_W'(RST_LEN)));
  assert_warm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && $past(rst_req) && !$past(fire)) |-> $stable(rst_warm));
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_enable_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_q) |=> en_q);
  assert_runs_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> en_q);
endmodule

bind wdog_twostage wdog_twostage_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_req   (rst_req),
  .rst_warm  (rst_warm),
  .tout_flag (tout_flag),
  .expire    (expire),
  .fire      (fire),
  .lock_q    (lock_q),
  .en_q      (en_q),
  .ul_open   (ul_open),
  .pre1_q    (pre1_q),
  .pre2_q    (pre2_q)
);

// File: tb/test_wdog_twostage.sv
module test_wdog_twostage;
  import wdog_pkg::*;

  localparam int LOW_W_TB   = 2;
  localparam int PRESC_W_TB = 2;
  localparam int RST_LEN_TB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       rst_req, rst_warm, tout_flag, tout_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wdog_twostage #(.PRE_W(20), .LOW_W(LOW_W_TB), .PRESC_W(PRESC_W_TB),
                  .RST_LEN(RST_LEN_TB), .ADDR_W(5)) i_wdog_twostage (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .rst_warm(rst_warm), .tout_flag(tout_flag), .tout_pin(tout_pin)
  );

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // All bus tasks start and end just after a falling edge.
  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    bus_addr = a[4:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    bus_addr = a[4:0]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic keyed(logic [7:0] a, logic [7:0] d);
    bus_write(OFS_KEY, KEY_FIRST);
    bus_write(OFS_KEY, KEY_SECOND);
    bus_write(a, d);
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(logic [7:0] p1, logic [7:0] p2, logic [7:0] ctl);
    bus_write(OFS_LOCK, 8'h00);
    keyed(OFS_KICK, 8'h02);
    keyed(OFS_PRE1, p1);
    keyed(OFS_PRE2, p2);
    bus_write(OFS_CTRL, ctl);
  endtask

  task automatic run_expiry(string tag, int exp_n, int exp_len, int exp_warm, int exp_tog);
    logic pin0;
    int k;
    int len;
    int warm;
    pin0 = tout_pin;
    k = 0;
    bus_write(OFS_LOCK, 8'h02);
    while (!tout_flag && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " expiry cycle"}, k, exp_n);
    warm = int'(rst_warm);
    len = 0;
    while (rst_req && len < 200) begin
      len++;
      @(negedge clk);
    end
    bus_write(OFS_LOCK, 8'h00);
    chk({tag, " reset length"}, len, exp_len);
    if (exp_len > 0) chk({tag, " reset type"}, warm, exp_warm);
    chk({tag, " pin toggled"}, int'(tout_pin != pin0), exp_tog);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    bus_read(OFS_PRE1, d); chk("R1 reset preload", d, 0);
    bus_read(OFS_LOCK, d); chk("R10 reset lock/enable", d, 0);
    chk("R6 reset flag", tout_flag, 0);
    chk("R7 reset req", rst_req, 0);
    chk("R9 reset pin", tout_pin, 0);
  endtask

  task automatic t_preload_mask();
    logic [7:0] d;
    keyed(8'h02, 8'hFF); bus_read(8'h02, d); chk("R1 byte2 masked", d, 8'h0F);
    keyed(8'h03, 8'hFF); bus_read(8'h03, d); chk("R1 byte3 zero", d, 0);
    keyed(8'h06, 8'hA5); bus_read(8'h06, d); chk("R1 pre2 byte2 masked", d, 8'h05);
    keyed(8'h02, 8'h00); keyed(8'h06, 8'h00);
  endtask

  task automatic t_unlock();
    logic [7:0] d;
    bus_write(OFS_PRE1, 8'h11);
    bus_read(OFS_PRE1, d); chk("R2 no key ignored", d, 0);
    bus_write(OFS_KEY, KEY_FIRST); bus_write(OFS_KEY, 8'h55); bus_write(OFS_KEY, KEY_SECOND);
    bus_write(OFS_PRE1, 8'h22);
    bus_read(OFS_PRE1, d); chk("R3 broken key ignored", d, 0);
    keyed(OFS_PRE1, 8'h33);
    bus_read(OFS_PRE1, d); chk("R2 keyed write taken", d, 8'h33);
    bus_write(8'h01, 8'h44);
    bus_read(8'h01, d); chk("R3 key spent", d, 0);
    keyed(OFS_PRE1, 8'h00);
  endtask

  task automatic t_flag_clear();
    bus_write(OFS_KICK, 8'h02);
    chk("R6 unkeyed clear ignored", tout_flag, 1);
    keyed(OFS_KICK, 8'h02);
    chk("R6 keyed clear", tout_flag, 0);
  endtask

  task automatic t_disable_hold();
    logic [7:0] d;
    setup(8'd5, 8'd5, 8'h00);
    bus_write(OFS_LOCK, 8'h02);
    repeat (10) @(negedge clk);
    bus_write(OFS_LOCK, 8'h00);
    repeat (100) @(negedge clk);
    chk("R11 disabled no timeout", tout_flag, 0);
    bus_read(OFS_CNT, d); chk("R11 idle counter view", d, 20);
  endtask

  task automatic t_keepalive();
    logic [7:0] d;
    setup(8'd5, 8'd5, 8'h00);
    bus_write(OFS_LOCK, 8'h02);
    for (int i = 0; i < 5; i++) begin
      repeat (30) @(negedge clk);
      keyed(OFS_KICK, 8'h01);
      bus_read(OFS_CNT, d);
      chk("R11 reload view", d, 20);
    end
    chk("R11 keepalive no timeout", tout_flag, 0);
    bus_write(OFS_LOCK, 8'h00);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    setup(8'd5, 8'd5, 8'h00);
    bus_write(OFS_LOCK, 8'h03);
    bus_read(OFS_LOCK, d); chk("R10 lock and enable set", d, 3);
    bus_write(OFS_LOCK, 8'h00);
    bus_read(OFS_LOCK, d); chk("R10 disable ignored when locked", d, 3);
    hw_reset();
    bus_read(OFS_LOCK, d); chk("R10 lock cleared by reset", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    hw_reset();
    t_reset_state();
    t_preload_mask();
    t_unlock();
    // R4: P1=0,P2=1 -> 0*4+1 + 1*4+1 = 6 ticks; R7 off; R9 toggles
    setup(8'd0, 8'd1, 8'h00);
    run_expiry("R4 P1=0", 6, 0, 0, 1);
    t_flag_clear();
    // R4: P1=2,P2=1 -> 9 + 5 = 14
    setup(8'd2, 8'd1, 8'h00);
    run_expiry("R4 P1=2", 14, 0, 0, 1);
    // R5: prescaler, 6 ticks of 4 clocks
    setup(8'd0, 8'd1, 8'h04);
    run_expiry("R5 prescaled", 24, 0, 0, 1);
    // R7 cold reset, R8
    setup(8'd5, 8'd5, 8'h10);
    run_expiry("R7 cold", 42, RST_LEN_TB, 0, 1);
    // R8 warm, R9 toggle masked
    setup(8'd5, 8'd5, 8'h38);
    run_expiry("R8 R9 warm quiet", 42, RST_LEN_TB, 1, 0);
    t_disable_hold();
    t_keepalive();
    t_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule